// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block sits next to a simple in-order processor and decides when the processor leaves its instruction stream for the trap handler. Each cycle it looks at the synchronous fault flags raised by the instruction now executing, and at a set of sticky pending interrupt bits. If one of them must be taken, it redirects the program counter to a single fixed handler address in the same cycle. At the clock edge it saves the interrupted PC, records what happened and raises privilege. It also turns off interrupt delivery globally.

Software reprograms a per-line enable mask through a write port and can drop pending bits through a clear port. A return strobe sends the processor back to the saved PC. The same strobe lowers privilege and turns global interrupt delivery back on. When several events compete in one cycle, a fixed order picks exactly one. Every other raised line stays pending.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When an entry is taken, the saved-PC output shows the value of `pc_i` from the entry cycle, starting on the next cycle.
- R2: On entry, `cause` is loaded with 0 for an interrupt, 1 for breakpoint, 2 for syscall, 3 for a privileged-instruction violation and 4 for an address fault. On an interrupt entry `cause_line` holds the delivered line number; on an exception entry it is 0.
- R3: In an entry cycle, `redirect_valid` is 1 and `redirect_pc` is `HANDLER_PC` (default 0xC0000000), combinationally.
- R4: Entry clears `gie` at the next edge. No interrupt is delivered while `gie` is 0.
- R5: An interrupt is delivered only if its pending bit and its `mask` bit (bit i enables line i) are both 1. A masked raised line stays pending and is delivered after it is unmasked.
- R6: Synchronous exceptions beat interrupts. Among exceptions the order is breakpoint, then syscall, then privileged violation, then address fault. Among interrupts the lowest-numbered eligible line wins.
- R7: Entry sets `priv` to 1 at the next edge.
- R8: `exc_privop` raises an exception with cause 3 when `priv` is 0. It is ignored when `priv` is 1.
- R9: A return strobe in a cycle with no entry redirects to the saved PC. At the next edge it clears `priv` and sets `gie`. An entry in the same cycle takes precedence over the return.
- R10: A pending bit is set by a 1 on its `irq` line. It is cleared only by its own delivery or by a `pend_clr_we` write with that bit set. A new request in the same cycle as a clear wins.
- R11: Reset gives `epc`=0, `cause`=0, `cause_line`=0, `mask`=0, `pending`=0, `gie`=0 and `priv`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | PC of the executing instruction |
| exc_brk | input | 1 | Breakpoint request |
| exc_sys | input | 1 | Syscall request |
| exc_privop | input | 1 | Executing instruction is privileged |
| exc_addr | input | 1 | Address fault request |
| irq | input | NIRQ | Interrupt request lines |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NIRQ | New mask value |
| pend_clr_we | input | 1 | Pending-clear strobe |
| pend_clr | input | NIRQ | Pending bits to clear |
| ret_i | input | 1 | Return-from-handler strobe |
| redirect_valid | output | 1 | PC redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| epc | output | XLEN | Saved PC |
| cause | output | 3 | Event code |
| cause_line | output | $clog2(NIRQ) | Delivered interrupt line |
| mask | output | NIRQ | Interrupt enable mask |
| pending | output | NIRQ | Pending interrupt bits |
| gie | output | 1 | Global interrupt enable |
| priv | output | 1 | Privilege level |

## Verification
The hardest state to reach from the ports combines three conditions at once. Several interrupt lines are pending while masked. A mask write then makes more than one of them eligible. At the same moment a synchronous exception competes with them, or a clear and a fresh request hit the same bit. Directed sequences set up those pending bits first, with interrupts globally off. They then re-enable delivery through a return and change the mask. Seeded random traffic then mixes rare exceptions, returns, mask writes and clears with bursty interrupt lines. A cycle-level bench model predicts every output.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int XLEN = 32,
  parameter int NIRQ = 8,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'hC000_0000,
  localparam int IDW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_i,
  input  logic            exc_brk,
  input  logic            exc_sys,
  input  logic            exc_privop,
  input  logic            exc_addr,
  input  logic [NIRQ-1:0] irq,
  input  logic            mask_we,
  input  logic [NIRQ-1:0] mask_wdata,
  input  logic            pend_clr_we,
  input  logic [NIRQ-1:0] pend_clr,
  input  logic            ret_i,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] epc,
  output logic [2:0]      cause,
  output logic [IDW-1:0]  cause_line,
  output logic [NIRQ-1:0] mask,
  output logic [NIRQ-1:0] pending,
  output logic            gie,
  output logic            priv
);
  localparam logic [2:0] C_IRQ  = 3'd0;
  localparam logic [2:0] C_BRK  = 3'd1;
  localparam logic [2:0] C_SYS  = 3'd2;
  localparam logic [2:0] C_PRIV = 3'd3;
  localparam logic [2:0] C_ADDR = 3'd4;

  logic            priv_viol, sync_take, irq_take, take;
  logic [NIRQ-1:0] eligible, deliver;
  logic [IDW-1:0]  irq_sel;
  logic [2:0]      sync_code;

  assign priv_viol = exc_privop & ~priv;
  assign sync_take = exc_brk | exc_sys | priv_viol | exc_addr;
  assign eligible  = pending & mask;
  assign irq_take  = gie & (|eligible) & ~sync_take;
  assign take      = sync_take | irq_take;

  always_comb begin
    irq_sel = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (eligible[i]) irq_sel = IDW'(i);
  end

  assign deliver = irq_take ? (NIRQ'(1) << irq_sel) : '0;

  always_comb begin
    if (exc_brk)        sync_code = C_BRK;
    else if (exc_sys)   sync_code = C_SYS;
    else if (priv_viol) sync_code = C_PRIV;
    else                sync_code = C_ADDR;
  end

  assign redirect_valid = take | ret_i;
  assign redirect_pc    = take ? HANDLER_PC : epc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc        <= '0;
      cause      <= C_IRQ;
      cause_line <= '0;
      mask       <= '0;
      pending    <= '0;
      gie        <= 1'b0;
      priv       <= 1'b1;
    end else begin
      pending <= (pending & ~(pend_clr_we ? pend_clr : '0) & ~deliver) | irq;
      if (mask_we) mask <= mask_wdata;
      if (take) begin
        epc        <= pc_i;
        cause      <= sync_take ? sync_code : C_IRQ;
        cause_line <= sync_take ? '0 : irq_sel;
        gie        <= 1'b0;
        priv       <= 1'b1;
      end else if (ret_i) begin
        gie  <= 1'b1;
        priv <= 1'b0;
      end
    end
  end
endmodule

module exc_entry_ctrl_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'hC000_0000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take,
  input logic            ret_i,
  input logic            exc_privop,
  input logic            priv,
  input logic            gie,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] epc,
  input logic [XLEN-1:0] redirect_pc,
  input logic            redirect_valid,
  input logic [2:0]      cause
);
  AST_ENTRY_EPC: assert property (@(posedge clk) disable iff (!rst_n) take |=> epc == $past(pc_i)); // R1
  AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) take |-> redirect_valid && redirect_pc == HANDLER_PC); // R3
  AST_ENTRY_GIE_OFF: assert property (@(posedge clk) disable iff (!rst_n) take |=> !gie); // R4
  AST_ENTRY_PRIV_UP: assert property (@(posedge clk) disable iff (!rst_n) take |=> priv); // R7
  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (take && !gie) |=> cause != 3'd0); // R4
  AST_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rst_n) (exc_privop && !priv) |-> take); // R8
  AST_RETURN_STATE: assert property (@(posedge clk) disable iff (!rst_n) (ret_i && !take) |=> gie && !priv); // R9
  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (ret_i && !take) |-> redirect_pc == epc); // R9
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .ret_i(ret_i), .exc_privop(exc_privop),
  .priv(priv), .gie(gie), .pc_i(pc_i), .epc(epc), .redirect_pc(redirect_pc),
  .redirect_valid(redirect_valid), .cause(cause)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  localparam int PERIOD = 10;
  localparam int XLEN = 32;
  localparam int NIRQ = 8;
  localparam int IDW = 3;
  localparam logic [31:0] HANDLER = 32'hC000_0000;

  logic clk = 0, rst_n = 0;
  logic [XLEN-1:0] pc_i = 0;
  logic exc_brk = 0, exc_sys = 0, exc_privop = 0, exc_addr = 0, ret_i = 0;
  logic [NIRQ-1:0] irq = 0, mask_wdata = 0, pend_clr = 0;
  logic mask_we = 0, pend_clr_we = 0;
  logic redirect_valid, gie, priv;
  logic [XLEN-1:0] redirect_pc, epc;
  logic [2:0] cause;
  logic [IDW-1:0] cause_line;
  logic [NIRQ-1:0] mask, pending;

  int errors = 0, checks = 0;

  logic [XLEN-1:0] m_epc;
  logic [2:0] m_cause;
  logic [IDW-1:0] m_line;
  logic [NIRQ-1:0] m_mask, m_pend;
  logic m_gie, m_priv;

  always #(PERIOD/2) clk = ~clk;

  exc_entry_ctrl uut (.*);

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic sync_any();
    return exc_brk | exc_sys | (exc_privop & ~m_priv) | exc_addr;
  endfunction

  function automatic logic [2:0] sync_code();
    if (exc_brk) return 3'd1;
    if (exc_sys) return 3'd2;
    if (exc_privop && !m_priv) return 3'd3;
    return 3'd4;
  endfunction

  function automatic int low_line(input logic [NIRQ-1:0] v);
    for (int i = 0; i < NIRQ; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic cycle(input string tag);
    logic s, it, tk;
    int ln;
    #1;
    s  = sync_any();
    ln = low_line(m_pend & m_mask);
    it = m_gie && ln >= 0 && !s;
    tk = s | it;
    chk("R11", "epc", epc, m_epc);
    chk("R2", "cause", {29'd0, cause}, {29'd0, m_cause});
    chk("R2", "cause_line", {29'd0, cause_line}, {29'd0, m_line});
    chk("R5", "mask", {24'd0, mask}, {24'd0, m_mask});
    chk("R10", "pending", {24'd0, pending}, {24'd0, m_pend});
    chk("R4", "gie", {31'd0, gie}, {31'd0, m_gie});
    chk("R7", "priv", {31'd0, priv}, {31'd0, m_priv});
    chk(tag, "redirect_valid", {31'd0, redirect_valid}, {31'd0, tk | ret_i});
    if (tk | ret_i) chk(tag, "redirect_pc", redirect_pc, tk ? HANDLER : m_epc);
    m_pend = (m_pend & ~(pend_clr_we ? pend_clr : 8'h0) & ~(it ? 8'(1 << ln) : 8'h0)) | irq;
    if (mask_we) m_mask = mask_wdata;
    if (tk) begin
      m_epc = pc_i; m_cause = s ? sync_code() : 3'd0;
      m_line = s ? '0 : IDW'(ln); m_gie = 0; m_priv = 1;
    end else if (ret_i) begin
      m_gie = 1; m_priv = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    exc_brk = 0; exc_sys = 0; exc_privop = 0; exc_addr = 0; ret_i = 0;
    irq = 0; mask_we = 0; pend_clr_we = 0; pend_clr = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    m_epc = 0; m_cause = 0; m_line = 0; m_mask = 0; m_pend = 0; m_gie = 0; m_priv = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11", "reset priv", {31'd0, priv}, 32'd1);
    chk("R11", "reset gie", {31'd0, gie}, 32'd0);
    chk("R11", "reset pending", {24'd0, pending}, 32'd0);

    // R6: breakpoint and syscall together -> breakpoint
    idle(); pc_i = 32'h100; exc_brk = 1; exc_sys = 1; cycle("R6");
    chk("R1", "epc after entry", epc, 32'h100);
    chk("R6", "cause brk wins", {29'd0, cause}, 32'd1);
    // R8: privileged op with priv=1 is ignored
    idle(); exc_privop = 1; cycle("R8");
    // R5/R4: lines pend while gie=0 and masked
    idle(); irq = 8'b0010_1100; cycle("R4");
    idle(); cycle("R4");
    chk("R10", "sticky pending", {24'd0, pending}, 32'h2C);
    // R9: return enables gie, drops priv
    idle(); ret_i = 1; cycle("R9");
    chk("R9", "priv after return", {31'd0, priv}, 32'd0);
    // R8: privileged op with priv=0 traps with cause 3
    idle(); pc_i = 32'h200; exc_privop = 1; cycle("R8");
    chk("R8", "cause priv", {29'd0, cause}, 32'd3);
    idle(); ret_i = 1; cycle("R9");
    // R5: masked lines still do not fire
    idle(); cycle("R5");
    idle(); mask_we = 1; mask_wdata = 8'b0010_1000; cycle("R5");
    // R6: lowest eligible line 3 delivered
    idle(); pc_i = 32'h300; cycle("R6");
    chk("R6", "line 3 delivered", {29'd0, cause_line}, 32'd3);
    // R10: explicit clear vs fresh request on the same bit
    idle(); pend_clr_we = 1; pend_clr = 8'b0010_0100; irq = 8'b0000_0100; cycle("R10");
    chk("R10", "set wins over clear", {24'd0, pending}, 32'h04);
    // R9: entry beats return in same cycle
    idle(); ret_i = 1; exc_addr = 1; cycle("R9");
    chk("R2", "addr fault cause", {29'd0, cause}, 32'd4);
    // R6: exception beats eligible interrupt
    idle(); ret_i = 1; cycle("R9");
    idle(); mask_we = 1; mask_wdata = 8'hFF; cycle("R5");
    idle(); pc_i = 32'h400; exc_sys = 1; cycle("R6");
    chk("R6", "sync over irq", {29'd0, cause}, 32'd2);

    for (int n = 0; n < 3000; n++) begin
      idle();
      pc_i = $urandom;
      exc_brk    = ($urandom % 40) == 0;
      exc_sys    = ($urandom % 40) == 0;
      exc_privop = ($urandom % 10) == 0;
      exc_addr   = ($urandom % 40) == 0;
      ret_i      = ($urandom % 8) == 0;
      if (($urandom % 4) == 0) irq = 8'($urandom) & 8'($urandom);
      mask_we = ($urandom % 12) == 0; mask_wdata = 8'($urandom);
      pend_clr_we = ($urandom % 15) == 0; pend_clr = 8'($urandom);
      cycle("R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule